// File: doc/BRIEF.md
# Priority Vector Request and Service Tracker

The tracker holds three 256-bit maps, one bit per interrupt vector: a request map, an in-service map and an enable map. A source raises a vector with a strobe; the request bit is set only if that vector is enabled, and a raise on a disabled vector is lost. The tracker searches both the request map and the in-service map for their highest set bit. It then presents a pending flag and the vector to deliver next. A larger vector number always has higher priority.

The consumer takes a vector with an acknowledge strobe, which moves it from request to in-service. When the consumer finishes, it signals end-of-interrupt. This retires whichever in-service vector is highest, so no vector number is supplied. A word-wide port reads any 32-bit slice of the three maps and writes slices of the enable map. The design has no sequencing states: every strobe takes effect at the next clock edge, and the pending flag and next vector are derived combinationally from the stored maps.

Top module: `vt_tracker`

## Requirements
- R1: After reset the request and in-service maps are all zero, every enable bit is one, pending is low and the next-vector output is zero.
- R2: A raise of vector v sets request bit v at the next clock edge when enable bit v is one. Vector v sits in word v/32, bit v%32, of each map.
- R3: A raise of a vector whose enable bit is zero leaves its request bit clear.
- R4: Pending is high exactly when some request bit is set and the highest request index is strictly greater than the highest in-service index. An empty in-service map counts as index -1, so vector 0 alone is deliverable.
- R5: While pending is high the next-vector output equals the highest request index. While pending is low it reads zero.
- R6: An acknowledge of vector v sets in-service bit v and clears request bit v in the same clock edge.
- R7: End-of-interrupt clears only the highest set in-service bit and leaves every other in-service bit unchanged.
- R8: End-of-interrupt with an empty in-service map changes none of the three maps.
- R9: When a raise and an acknowledge name the same vector in one cycle, the acknowledge wins: request bit clear, in-service bit set.
- R10: The read port returns the word selected by index from the request map (select 0), the in-service map (select 1) or the enable map (select 2), and zero for select 3. The value is combinational.
- R11: An enable-word write replaces that 32-bit slice of the enable map at the next edge and does not clear request bits that are already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_stb | input | 1 | Raise request strobe |
| raise_vec | input | 8 | Vector to raise |
| ack_stb | input | 1 | Begin-service strobe |
| ack_vec | input | 8 | Vector taken into service |
| eoi_stb | input | 1 | End-of-interrupt strobe |
| en_wr_stb | input | 1 | Enable-word write strobe |
| en_wr_idx | input | 3 | Enable word index |
| en_wr_data | input | 32 | Enable word value |
| rd_sel | input | 2 | Map select for the read port |
| rd_idx | input | 3 | Word index for the read port |
| rd_data | output | 32 | Selected map word |
| pending | output | 1 | A deliverable vector exists |
| next_vec | output | 8 | Vector to deliver next, zero when not pending |

## Verification
The delivery decision is tested with a request above the in-service vector, below it and equal to it. The equal case separates a strictly-greater comparison from greater-or-equal. A lone request for vector 0 with nothing in service checks the -1 convention. End-of-interrupt is applied with two vectors in service, to show it removes only the top one, and again with none in service. A raise is sent into a disabled word, and a word holding an existing request is later disabled, to show that the enable map filters new raises only. A raise and an acknowledge on the same vector in one cycle settle which of the two wins.

// File: rtl/vt_pkg.sv
package vt_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        MAP_REQ  = 2'd0,
        MAP_SVC  = 2'd1,
        MAP_EN   = 2'd2,
        MAP_NONE = 2'd3
    } map_sel_e;
endpackage

// File: rtl/vt_top_find.sv
module vt_top_find #(
    parameter int W = 256,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    // ascending scan: the last hit, i.e. the highest index, wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vt_vec_store.sv
module vt_vec_store #(
    parameter int NVEC = 256,
    localparam int VW  = $clog2(NVEC),
    localparam int NW  = NVEC / vt_pkg::WORD_W,
    localparam int WIW = $clog2(NW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raise_stb,
    input  logic [VW-1:0]   raise_vec,
    input  logic            ack_stb,
    input  logic [VW-1:0]   ack_vec,
    input  logic            svc_clr,
    input  logic [VW-1:0]   svc_clr_vec,
    input  logic            en_wr_stb,
    input  logic [WIW-1:0]  en_wr_idx,
    input  logic [vt_pkg::WORD_W-1:0] en_wr_data,
    output logic [NVEC-1:0] req_map,
    output logic [NVEC-1:0] svc_map,
    output logic [NVEC-1:0] en_map
);
    localparam int WW = vt_pkg::WORD_W;

    logic [NVEC-1:0] raise_mask, ack_mask, clr_mask;

    always_comb begin
        raise_mask = raise_stb ? ((NVEC'(1) << raise_vec) & en_map) : '0;
        ack_mask   = ack_stb   ?  (NVEC'(1) << ack_vec)             : '0;
        clr_mask   = svc_clr   ?  (NVEC'(1) << svc_clr_vec)         : '0;
    end

    // acknowledge is applied last so it wins over a same-cycle raise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_map <= '0;
            svc_map <= '0;
        end else begin
            req_map <= (req_map | raise_mask) & ~ack_mask;
            svc_map <= (svc_map & ~clr_mask) | ack_mask;
        end
    end

    for (genvar g = 0; g < NW; g++) begin : g_en_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_map[g*WW +: WW] <= '1;
            else if (en_wr_stb && en_wr_idx == WIW'(g))
                en_map[g*WW +: WW] <= en_wr_data;
        end
    end

    p_ack_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> (svc_map[$past(ack_vec)] && !req_map[$past(ack_vec)]));

    p_drop_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_stb && !en_map[raise_vec] && !req_map[raise_vec]) |=> !req_map[$past(raise_vec)]);

    p_ack_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_stb && ack_stb && raise_vec == ack_vec) |=> !req_map[$past(raise_vec)]);

    p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_stb && en_map[raise_vec] && !(ack_stb && ack_vec == raise_vec)) |=> req_map[$past(raise_vec)]);
endmodule

// File: rtl/vt_tracker.sv
module vt_tracker #(
    parameter int NVEC = 256,
    localparam int VW  = $clog2(NVEC),
    localparam int NW  = NVEC / vt_pkg::WORD_W,
    localparam int WIW = $clog2(NW)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      raise_stb,
    input  logic [VW-1:0]             raise_vec,
    input  logic                      ack_stb,
    input  logic [VW-1:0]             ack_vec,
    input  logic                      eoi_stb,
    input  logic                      en_wr_stb,
    input  logic [WIW-1:0]            en_wr_idx,
    input  logic [vt_pkg::WORD_W-1:0] en_wr_data,
    input  logic [1:0]                rd_sel,
    input  logic [WIW-1:0]            rd_idx,
    output logic [vt_pkg::WORD_W-1:0] rd_data,
    output logic                      pending,
    output logic [VW-1:0]             next_vec
);
    import vt_pkg::*;

    logic [NVEC-1:0] req_map, svc_map, en_map;
    logic            req_found, svc_found;
    logic [VW-1:0]   req_top, svc_top;
    map_sel_e        sel;

    vt_top_find #(.W(NVEC)) u_req_find (.bits(req_map), .found(req_found), .idx(req_top));
    vt_top_find #(.W(NVEC)) u_svc_find (.bits(svc_map), .found(svc_found), .idx(svc_top));

    vt_vec_store #(.NVEC(NVEC)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise_stb   (raise_stb),
        .raise_vec   (raise_vec),
        .ack_stb     (ack_stb),
        .ack_vec     (ack_vec),
        .svc_clr     (eoi_stb && svc_found),
        .svc_clr_vec (svc_top),
        .en_wr_stb   (en_wr_stb),
        .en_wr_idx   (en_wr_idx),
        .en_wr_data  (en_wr_data),
        .req_map     (req_map),
        .svc_map     (svc_map),
        .en_map      (en_map)
    );

    // empty in-service map behaves as index -1
    always_comb begin
        pending  = req_found && (!svc_found || req_top > svc_top);
        next_vec = pending ? req_top : '0;
    end

    always_comb begin
        sel = map_sel_e'(rd_sel);
        unique case (sel)
            MAP_REQ:  rd_data = req_map[{rd_idx, 5'b0} +: WORD_W];
            MAP_SVC:  rd_data = svc_map[{rd_idx, 5'b0} +: WORD_W];
            MAP_EN:   rd_data = en_map[{rd_idx, 5'b0} +: WORD_W];
            MAP_NONE: rd_data = '0;
        endcase
    end

    p_pend_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (req_map != '0));

    p_idle_vec_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> (next_vec == '0));

    p_eoi_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && !ack_stb && svc_map != '0) |=> ($countones(svc_map) == $countones($past(svc_map)) - 1));

    p_spurious_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && !ack_stb && svc_map == '0) |=> (svc_map == '0));
endmodule

// File: tb/tb_vt_tracker.sv
`timescale 1ns/1ps
module tb_vt_tracker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        raise_stb, ack_stb, eoi_stb, en_wr_stb;
    logic [7:0]  raise_vec, ack_vec;
    logic [2:0]  en_wr_idx, rd_idx;
    logic [31:0] en_wr_data, rd_data;
    logic [1:0]  rd_sel;
    logic        pending;
    logic [7:0]  next_vec;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vt_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .raise_stb(raise_stb), .raise_vec(raise_vec),
        .ack_stb(ack_stb), .ack_vec(ack_vec),
        .eoi_stb(eoi_stb),
        .en_wr_stb(en_wr_stb), .en_wr_idx(en_wr_idx), .en_wr_data(en_wr_data),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
        .pending(pending), .next_vec(next_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, input logic [2:0] i, output logic [31:0] d);
        rd_sel = s; rd_idx = i; #1; d = rd_data;
    endtask

    task automatic chk_word(input string req, input logic [1:0] s, input logic [2:0] i, input logic [31:0] exp);
        logic [31:0] d;
        rd(s, i, d);
        chk(req, d, exp);
    endtask

    task automatic chk_out(input string req, input logic p, input logic [7:0] v);
        chk({req, " pending"}, {31'b0, pending}, {31'b0, p});
        chk({req, " next_vec"}, {24'b0, next_vec}, {24'b0, v});
    endtask

    // one-cycle strobes, applied at a falling edge, result seen at the next
    task automatic do_raise(input logic [7:0] v);
        @(negedge clk); raise_stb = 1; raise_vec = v;
        @(negedge clk); raise_stb = 0;
    endtask
    task automatic do_ack(input logic [7:0] v);
        @(negedge clk); ack_stb = 1; ack_vec = v;
        @(negedge clk); ack_stb = 0;
    endtask
    task automatic do_eoi();
        @(negedge clk); eoi_stb = 1;
        @(negedge clk); eoi_stb = 0;
    endtask
    task automatic do_en(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk); en_wr_stb = 1; en_wr_idx = i; en_wr_data = d;
        @(negedge clk); en_wr_stb = 0;
    endtask

    task automatic t_reset();
        chk_out("R1", 1'b0, 8'd0);
        for (int i = 0; i < 8; i++) begin
            chk_word("R1 req", 2'd0, 3'(i), 32'h0);
            chk_word("R1 svc", 2'd1, 3'(i), 32'h0);
            chk_word("R1 en", 2'd2, 3'(i), 32'hffff_ffff);
        end
        chk_word("R10 sel3", 2'd3, 3'd0, 32'h0);
    endtask

    task automatic t_raise();
        do_raise(8'h45);                       // word 2 bit 5
        chk_word("R2 R10", 2'd0, 3'd2, 32'h0000_0020);
        chk_out("R4 R5 raise", 1'b1, 8'h45);
    endtask

    task automatic t_enable();
        do_en(3'd3, 32'h0);
        chk_word("R11 en write", 2'd2, 3'd3, 32'h0);
        do_raise(8'd100);                      // word 3 bit 4, disabled
        chk_word("R3", 2'd0, 3'd3, 32'h0);
        chk_out("R3 outputs", 1'b1, 8'h45);
        do_en(3'd2, 32'h0);
        chk_word("R11 keep req", 2'd0, 3'd2, 32'h0000_0020);
        do_en(3'd2, 32'hffff_ffff);
        do_en(3'd3, 32'hffff_ffff);
    endtask

    task automatic t_ack();
        do_ack(8'h45);
        chk_word("R6 svc", 2'd1, 3'd2, 32'h0000_0020);
        chk_word("R6 req", 2'd0, 3'd2, 32'h0);
        chk_out("R5 idle", 1'b0, 8'd0);
    endtask

    task automatic t_compare();
        do_raise(8'h30);                       // below in-service 0x45
        chk_out("R4 lower", 1'b0, 8'd0);
        do_raise(8'h45);                       // equal
        chk_out("R4 equal", 1'b0, 8'd0);
        do_raise(8'h80);                       // above
        chk_out("R4 higher", 1'b1, 8'h80);
    endtask

    task automatic t_eoi();
        do_ack(8'h80);
        chk_out("R4 after ack", 1'b0, 8'd0);
        do_eoi();
        chk_word("R7 top cleared", 2'd1, 3'd4, 32'h0);
        chk_word("R7 lower kept", 2'd1, 3'd2, 32'h0000_0020);
        chk_out("R4 equal again", 1'b0, 8'd0);
        do_eoi();
        chk_word("R7 second", 2'd1, 3'd2, 32'h0);
        chk_out("R4 R5 none in service", 1'b1, 8'h45);
    endtask

    task automatic t_spurious();
        do_ack(8'h45);
        do_ack(8'h30);
        do_eoi();
        do_eoi();
        do_eoi();                              // nothing in service now
        for (int i = 0; i < 8; i++) begin
            chk_word("R8 req", 2'd0, 3'(i), 32'h0);
            chk_word("R8 svc", 2'd1, 3'(i), 32'h0);
            chk_word("R8 en", 2'd2, 3'(i), 32'hffff_ffff);
        end
        chk_out("R8 outputs", 1'b0, 8'd0);
    endtask

    task automatic t_same();
        @(negedge clk);
        raise_stb = 1; raise_vec = 8'hff; ack_stb = 1; ack_vec = 8'hff;
        @(negedge clk);
        raise_stb = 0; ack_stb = 0;
        chk_word("R9 req", 2'd0, 3'd7, 32'h0);
        chk_word("R9 svc", 2'd1, 3'd7, 32'h8000_0000);
        chk_out("R9 outputs", 1'b0, 8'd0);
        do_eoi();
    endtask

    task automatic t_zero();
        do_raise(8'h00);
        chk_word("R2 vec0", 2'd0, 3'd0, 32'h0000_0001);
        chk_out("R4 vec0 deliverable", 1'b1, 8'h00);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; raise_stb = 0; ack_stb = 0; eoi_stb = 0; en_wr_stb = 0;
        raise_vec = 0; ack_vec = 0; en_wr_idx = 0; en_wr_data = 0;
        rd_sel = 0; rd_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_raise();
        t_enable();
        t_ack();
        t_compare();
        t_eoi();
        t_spurious();
        t_same();
        t_zero();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule